// File: doc/BRIEF.md
# Link Interface Ownership Controller

This block sits on the physical-layer side of the narrow parallel interface that joins a serial-bus physical layer to its link layer. The interface is a 2-bit control field and a 4-bit data field, driven by either side. Every clock the block decides whether the physical layer drives these lines. It decides what value goes out, or whether the lines are left to the link.

After an arbitration win the block hands the interface to the link with a one-cycle grant code and one idle cycle. It then follows the link's hold, transmit and release codes. When the link ends a packet with hold, the block waits a fixed gap and grants again without new arbitration. It compares the requested speed with the speed latched at the first grant of that ownership. When the serial bus shows data-on, the block frames the incoming packet toward the link with a preamble, a speed code and the symbols. It returns to idle when data-on goes away, whether or not a packet arrived.

Top module: `phy_link_owner`

## Requirements
- R1: During and right after reset, `phy_oe` is 1, `ctl_out` is 2'b00, `d_out` is 0, and `bus_hold` and `speed_err` are 0.
- R2: When `arb_won` is sampled in idle with `data_on` low, the next cycle shows `ctl_out`=2'b11. The cycle after shows `ctl_out`=2'b00. From the third cycle `phy_oe` is 0.
- R3: While the link owns the interface and has not yet sent transmit (link code 2'b10), each sampled hold (link code 2'b01) raises `bus_hold` in the following cycle.
- R4: Once transmit has been seen, a sampled link idle (2'b00) keeps `phy_oe` at 0 for one more cycle. After that the block drives `ctl_out`=2'b00 with `phy_oe`=1.
- R5: Once transmit has been seen, a sampled link hold leaves `phy_oe` at 0 for one cycle. The block then drives 2'b00 for `GAP_CYC` cycles, then issues the 2'b11, 2'b00 grant again and tristates, all without `arb_won`.
- R6: `grant_speed` takes `req_speed` at a grant that follows `arb_won` and keeps it through re-grants. `speed_err` is 1 exactly in a re-grant cycle whose `req_speed` differs from `grant_speed`.
- R7: When `data_on` is sampled high in idle, the next cycle shows `ctl_out`=2'b10 and `d_out`=4'hF. If `arb_won` is high in the same cycle, it is dropped.
- R8: In receive, a sampled `rx_spd_valid` puts the speed code on `d_out` in the next cycle: 4'h2 (bit 1 set) for 200 Mb/s when `rx_spd_200` is 1, and 4'h0 for 100 Mb/s.
- R9: In receive, a sampled `rx_sym_valid` puts `rx_sym` on `d_out` in the next cycle at 200 Mb/s, or only bits 1:0 of it (bits 3:2 zero) at 100 Mb/s. With no valid input, `d_out` holds.
- R10: When `data_on` is sampled low in receive, the next cycle shows `ctl_out`=2'b00 and `d_out`=0. This also holds when no speed code was ever given.
- R11: While the link owns the interface, or while a grant is in progress, `arb_won` and `data_on` have no effect. `phy_oe` stays as the grant sequence dictates.
- R12: `phy_oe` falls only after a 2'b11 cycle followed by a 2'b00 cycle, and it rises only with `ctl_out`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_won | input | 1 | Arbitration won for a link request |
| req_speed | input | 2 | Speed of the pending link request |
| data_on | input | 1 | Serial bus is in the data-on state |
| rx_spd_valid | input | 1 | Speed of the incoming packet is known |
| rx_spd_200 | input | 1 | Incoming packet is at 200 Mb/s |
| rx_sym_valid | input | 1 | A received symbol is present |
| rx_sym | input | 4 | Received symbol |
| link_ctl | input | 2 | Registered control code from the link |
| phy_oe | output | 1 | Physical layer drives control and data |
| ctl_out | output | 2 | Control code driven by the physical layer |
| d_out | output | 4 | Data driven by the physical layer |
| bus_hold | output | 1 | Keep the serial bus in data-on for a link hold |
| grant_speed | output | 2 | Speed latched for the current ownership |
| speed_err | output | 1 | Re-grant requested at a different speed |

## Verification
The hardest state to reach is the re-grant after a hold that ends a packet. The stimulus must win the bus, play the link's transmit codes and end them with hold. It must then wait out the full gap. Only then can a changed request speed show up as `speed_err`. The bench does this in a directed sequence and changes `req_speed` during the gap. A second sequence raises `data_on` and `arb_won` while the link owns the interface, to show that both are ignored.

// File: rtl/plo_pkg.sv
// Shared codes for the link interface ownership controller.
// Assumes a 2-bit control field and a 4-bit data field.
package plo_pkg;
    typedef enum logic [1:0] {
        PC_IDLE   = 2'b00,
        PC_STATUS = 2'b01,
        PC_RECV   = 2'b10,
        PC_GRANT  = 2'b11
    } phy_ctl_e;

    typedef enum logic [1:0] {
        LC_IDLE = 2'b00,
        LC_HOLD = 2'b01,
        LC_XMIT = 2'b10,
        LC_RSVD = 2'b11
    } link_ctl_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_GRANT,
        ST_GRANT_IDLE,
        ST_LINK,
        ST_RELEASE,
        ST_TRAIL,
        ST_GAP
    } own_st_e;

    localparam logic [3:0] RX_PREAMBLE  = 4'hF;
    localparam logic [3:0] SPD_CODE_100 = 4'h0;
    localparam logic [3:0] SPD_CODE_200 = 4'h2;
endpackage

// File: rtl/plo_own_fsm.sv
// Ownership state machine: grant, link tracking, release, hold gap and receive entry.
// Assumes link_ctl is already registered by the pad logic and that
// arb_won is a one-cycle pulse.
module plo_own_fsm
    import plo_pkg::*;
#(
    parameter int unsigned GAP_CYC = 4,
    parameter int unsigned SPD_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_won,
    input  logic [SPD_W-1:0] req_speed,
    input  logic             data_on,
    input  logic [1:0]       link_ctl,
    output own_st_e          state_q,
    output logic             rx_enter,
    output logic             rx_stay,
    output logic             bus_hold,
    output logic [SPD_W-1:0] grant_speed,
    output logic             speed_err
);
    localparam int unsigned CNT_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    own_st_e          state_d;
    logic             seen_q;
    logic [CNT_W-1:0] gap_q;

    // Next-state decision from the present state and sampled inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (data_on)      state_d = ST_RECV;
                else if (arb_won) state_d = ST_GRANT;
            end
            ST_RECV:       if (!data_on) state_d = ST_IDLE;
            ST_GRANT:      state_d = ST_GRANT_IDLE;
            ST_GRANT_IDLE: state_d = ST_LINK;
            ST_LINK: begin
                if (seen_q && link_ctl == LC_IDLE)      state_d = ST_RELEASE;
                else if (seen_q && link_ctl == LC_HOLD) state_d = ST_TRAIL;
            end
            ST_RELEASE:    state_d = ST_IDLE;
            ST_TRAIL:      state_d = ST_GAP;
            ST_GAP:        if (gap_q == GAP_LAST) state_d = ST_GRANT;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign rx_enter = (state_d == ST_RECV) && (state_q != ST_RECV);
    assign rx_stay  = (state_d == ST_RECV) && (state_q == ST_RECV);

    // State register with the transmit-seen flag and the gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seen_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_GRANT_IDLE)
                seen_q <= 1'b0;
            else if (state_q == ST_LINK && link_ctl == LC_XMIT)
                seen_q <= 1'b1;
            if (state_q == ST_GAP) gap_q <= gap_q + 1'b1;
            else                   gap_q <= '0;
        end
    end

    // Hold indication, speed latch and speed-mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_hold    <= 1'b0;
            grant_speed <= '0;
            speed_err   <= 1'b0;
        end else begin
            bus_hold  <= (state_q == ST_LINK) && !seen_q && (link_ctl == LC_HOLD);
            speed_err <= (state_q == ST_GAP) && (state_d == ST_GRANT)
                         && (req_speed != grant_speed);
            if (state_q == ST_IDLE && state_d == ST_GRANT)
                grant_speed <= req_speed;
        end
    end
endmodule

// File: rtl/plo_rx_framer.sv
// Receive framer: drives the preamble, speed code and symbols on the data field.
// Assumes the speed code arrives before the symbols; a speed code wins
// over a symbol in the same cycle.
module plo_rx_framer
    import plo_pkg::*;
#(
    parameter int unsigned D_W  = 4,
    parameter int unsigned LO_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_enter,
    input  logic           rx_stay,
    input  logic           rx_spd_valid,
    input  logic           rx_spd_200,
    input  logic           rx_sym_valid,
    input  logic [D_W-1:0] rx_sym,
    output logic [D_W-1:0] rx_d
);
    localparam logic [D_W-1:0] LO_MASK = D_W'((1 << LO_W) - 1);

    logic fast_q;

    // Data register and latched receive speed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_d   <= '0;
            fast_q <= 1'b0;
        end else if (rx_enter) begin
            rx_d   <= RX_PREAMBLE;
            fast_q <= 1'b0;
        end else if (rx_stay) begin
            if (rx_spd_valid) begin
                fast_q <= rx_spd_200;
                rx_d   <= rx_spd_200 ? SPD_CODE_200 : SPD_CODE_100;
            end else if (rx_sym_valid) begin
                rx_d   <= fast_q ? rx_sym : (rx_sym & LO_MASK);
            end
        end else begin
            rx_d <= '0;
        end
    end
endmodule

// File: rtl/phy_link_owner.sv
// Top of the link interface ownership controller. It decodes the
// ownership state into the control code, the data field and the output enable.
// Assumes the pads turn phy_oe into the tristate control of ctl_out and d_out.
module phy_link_owner
    import plo_pkg::*;
#(
    parameter int unsigned GAP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arb_won,
    input  logic [1:0] req_speed,
    input  logic       data_on,
    input  logic       rx_spd_valid,
    input  logic       rx_spd_200,
    input  logic       rx_sym_valid,
    input  logic [3:0] rx_sym,
    input  logic [1:0] link_ctl,
    output logic       phy_oe,
    output logic [1:0] ctl_out,
    output logic [3:0] d_out,
    output logic       bus_hold,
    output logic [1:0] grant_speed,
    output logic       speed_err
);
    own_st_e    state_q;
    logic       rx_enter;
    logic       rx_stay;
    logic [3:0] rx_d;

    plo_own_fsm #(.GAP_CYC(GAP_CYC), .SPD_W(2)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arb_won     (arb_won),
        .req_speed   (req_speed),
        .data_on     (data_on),
        .link_ctl    (link_ctl),
        .state_q     (state_q),
        .rx_enter    (rx_enter),
        .rx_stay     (rx_stay),
        .bus_hold    (bus_hold),
        .grant_speed (grant_speed),
        .speed_err   (speed_err)
    );

    plo_rx_framer #(.D_W(4), .LO_W(2)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_enter     (rx_enter),
        .rx_stay      (rx_stay),
        .rx_spd_valid (rx_spd_valid),
        .rx_spd_200   (rx_spd_200),
        .rx_sym_valid (rx_sym_valid),
        .rx_sym       (rx_sym),
        .rx_d         (rx_d)
    );

    // Output decode from the registered ownership state.
    always_comb begin
        phy_oe = 1'b1;
        d_out  = '0;
        unique case (state_q)
            ST_RECV: begin
                ctl_out = PC_RECV;
                d_out   = rx_d;
            end
            ST_GRANT:                       ctl_out = PC_GRANT;
            ST_LINK, ST_RELEASE, ST_TRAIL: begin
                ctl_out = PC_IDLE;
                phy_oe  = 1'b0;
            end
            default:                        ctl_out = PC_IDLE;
        endcase
    end
endmodule

// File: rtl/plo_checker.sv
// Protocol checker for the ownership controller, bound to the top module.
module plo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       data_on,
    input logic       phy_oe,
    input logic [1:0] ctl_out,
    input logic [3:0] d_out,
    input logic       bus_hold,
    input logic       speed_err
);
    p_grant_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out == 2'b11 |=> (ctl_out == 2'b00 && phy_oe));

    p_grant_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out == 2'b11 |=> ##1 !phy_oe);

    p_hold_link_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> !phy_oe);

    p_reclaim_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_oe) |-> ctl_out == 2'b00);

    p_err_on_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        speed_err |-> ctl_out == 2'b11);

    p_preamble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out == 2'b10 && $past(ctl_out) != 2'b10) |-> d_out == 4'hF);

    p_rx_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out == 2'b10 && !data_on) |=> (ctl_out == 2'b00 && d_out == 4'h0));

    p_handover_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_oe) |-> ($past(ctl_out) == 2'b00 && $past(ctl_out, 2) == 2'b11));
endmodule

bind phy_link_owner plo_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_on   (data_on),
    .phy_oe    (phy_oe),
    .ctl_out   (ctl_out),
    .d_out     (d_out),
    .bus_hold  (bus_hold),
    .speed_err (speed_err)
);

// File: tb/phy_link_owner_test.sv
// Bench for the ownership controller: a behavioural reference model
// compared every clock, plus directed checks.
module phy_link_owner_test;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_won = 1'b0;
    logic [1:0] req_speed = 2'b00;
    logic       data_on = 1'b0;
    logic       rx_spd_valid = 1'b0;
    logic       rx_spd_200 = 1'b0;
    logic       rx_sym_valid = 1'b0;
    logic [3:0] rx_sym = 4'h0;
    logic [1:0] link_ctl = 2'b00;
    logic       phy_oe;
    logic [1:0] ctl_out;
    logic [3:0] d_out;
    logic       bus_hold;
    logic [1:0] grant_speed;
    logic       speed_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phy_link_owner #(.GAP_CYC(GAP)) uut (
        .clk (clk), .rst_n (rst_n), .arb_won (arb_won), .req_speed (req_speed),
        .data_on (data_on), .rx_spd_valid (rx_spd_valid), .rx_spd_200 (rx_spd_200),
        .rx_sym_valid (rx_sym_valid), .rx_sym (rx_sym), .link_ctl (link_ctl),
        .phy_oe (phy_oe), .ctl_out (ctl_out), .d_out (d_out), .bus_hold (bus_hold),
        .grant_speed (grant_speed), .speed_err (speed_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1 receive, 2 grant, 3 grant idle,
    // 4 link owns, 5 release, 6 trailing idle after hold, 7 gap.
    int ph = 0, seen = 0, gcnt = 0, md = 0, fast = 0, mspd = 0, ehold = 0, eerr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; seen = 0; gcnt = 0; md = 0; fast = 0; mspd = 0; ehold = 0; eerr = 0;
        end else begin
            ehold = (ph == 4 && seen == 0 && link_ctl == 2'b01) ? 1 : 0;
            eerr = 0;
            case (ph)
                0: if (data_on) begin ph = 1; md = 15; fast = 0; end
                   else if (arb_won) begin ph = 2; mspd = req_speed; end
                1: if (!data_on) begin ph = 0; md = 0; end
                   else if (rx_spd_valid) begin fast = rx_spd_200; md = rx_spd_200 ? 2 : 0; end
                   else if (rx_sym_valid) md = fast ? rx_sym : (rx_sym % 4);
                2: ph = 3;
                3: begin ph = 4; seen = 0; end
                4: if (link_ctl == 2'b10) seen = 1;
                   else if (seen == 1 && link_ctl == 2'b00) ph = 5;
                   else if (seen == 1 && link_ctl == 2'b01) ph = 6;
                5: ph = 0;
                6: begin ph = 7; gcnt = 0; end
                7: if (gcnt == GAP - 1) begin ph = 2; eerr = (req_speed != mspd) ? 1 : 0; end
                   else gcnt++;
                default: ph = 0;
            endcase
        end
    end

    function automatic string ptag(input int p);
        case (p)
            1: return "R7 receive ctl";
            2, 3: return "R2 grant";
            4: return "R11 link owns";
            5: return "R4 release";
            6, 7: return "R5 hold regrant";
            default: return "R10 idle";
        endcase
    endfunction

    // Compare the model against the outputs on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ptag(ph), ctl_out, (ph == 1) ? 2 : (ph == 2) ? 3 : 0);
            chk({ptag(ph), " oe R12"}, phy_oe, (ph == 4 || ph == 5 || ph == 6) ? 0 : 1);
            chk("R9 data field", d_out, (ph == 1) ? md : 0);
            chk("R3 bus_hold", bus_hold, ehold);
            chk("R6 speed_err", speed_err, eerr);
            chk("R6 grant_speed", grant_speed, mspd);
        end
    end

    task automatic step(input logic [1:0] lc);
        link_ctl = lc;
        @(negedge clk);
    endtask

    task automatic win(input logic [1:0] spd);
        arb_won = 1'b1; req_speed = spd;
        step(2'b00);
        arb_won = 1'b0;
        step(2'b00);
        step(2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset oe", phy_oe, 1);
        chk("R1 reset ctl", ctl_out, 0);
        chk("R1 reset d", d_out, 0);
        chk("R1 reset hold", bus_hold, 0);
        chk("R1 reset err", speed_err, 0);
        rst_n = 1'b1;
        step(2'b00);

        // Single packet with hold before transmit, then release.
        win(2'b01);
        chk("R2 tristate after grant", phy_oe, 0);
        step(2'b01);
        chk("R3 hold raises bus_hold", bus_hold, 1);
        step(2'b01);
        step(2'b10);
        step(2'b10);
        step(2'b00);
        chk("R4 still off after idle", phy_oe, 0);
        step(2'b00);
        chk("R4 reclaim oe", phy_oe, 1);
        chk("R4 reclaim ctl", ctl_out, 0);
        step(2'b00);

        // Hold at packet end, gap, re-grant at a different speed.
        win(2'b01);
        step(2'b10);
        step(2'b10);
        step(2'b01);
        chk("R5 off in trailing cycle", phy_oe, 0);
        req_speed = 2'b00;
        step(2'b00);
        chk("R5 gap driven idle", phy_oe, 1);
        for (int i = 0; i < GAP - 1; i++) step(2'b00);
        step(2'b00);
        chk("R5 regrant ctl", ctl_out, 3);
        chk("R6 mismatch flagged", speed_err, 1);
        chk("R6 speed kept", grant_speed, 1);
        step(2'b00);
        step(2'b00);
        // R11: receive and arbitration inputs while the link owns the bus.
        data_on = 1'b1; arb_won = 1'b1;
        step(2'b10);
        chk("R11 data_on ignored", phy_oe, 0);
        step(2'b10);
        data_on = 1'b0; arb_won = 1'b0;
        step(2'b00);
        step(2'b00);
        step(2'b00);

        // Receive at 200 Mb/s, receive wins over arbitration.
        data_on = 1'b1; arb_won = 1'b1; req_speed = 2'b10;
        step(2'b00);
        arb_won = 1'b0;
        chk("R7 receive code", ctl_out, 2);
        chk("R7 preamble", d_out, 15);
        rx_spd_valid = 1'b1; rx_spd_200 = 1'b1;
        step(2'b00);
        rx_spd_valid = 1'b0;
        chk("R8 200 code", d_out, 2);
        rx_sym_valid = 1'b1; rx_sym = 4'hA;
        step(2'b00);
        chk("R9 full symbol", d_out, 10);
        rx_sym_valid = 1'b0;
        step(2'b00);
        chk("R9 hold symbol", d_out, 10);
        data_on = 1'b0;
        step(2'b00);
        chk("R10 end ctl", ctl_out, 0);
        chk("R10 end d", d_out, 0);
        chk("R6 lost arbitration no latch", grant_speed, 1);
        step(2'b00);

        // Receive at 100 Mb/s with upper bits masked.
        data_on = 1'b1;
        step(2'b00);
        rx_spd_valid = 1'b1; rx_spd_200 = 1'b0;
        step(2'b00);
        rx_spd_valid = 1'b0;
        chk("R8 100 code", d_out, 0);
        rx_sym_valid = 1'b1; rx_sym = 4'hF;
        step(2'b00);
        chk("R9 masked symbol", d_out, 3);
        rx_sym_valid = 1'b0; data_on = 1'b0;
        step(2'b00);
        step(2'b00);

        // Aborted reception: data-on without a packet.
        data_on = 1'b1;
        step(2'b00);
        step(2'b00);
        data_on = 1'b0;
        step(2'b00);
        chk("R10 abort ends", ctl_out, 0);
        step(2'b00);
        step(2'b00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule